// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that is compared against a free-running 64-bit system count supplied from outside. Software reaches it over a simple 32-bit register bus that selects one of two 4 KB register windows: a refresh window, whose only job is to restart the countdown, and a control window, which holds the enable, the two stage flags, a 48-bit timeout offset and the live compare value.

While the watchdog is enabled, the compare value is loaded with the current count plus the offset whenever software refreshes it or rewrites the control or offset registers. When the count reaches the compare value for the first time, the block sets a first-stage flag, raises its interrupt and arms a second window of the same length. If that window also runs out before software refreshes, the block sets a second-stage flag and raises a reset request that stays high until the block itself is reset.

A bus access is one cycle with `bus_valid` high. `bus_frame` selects the window (0 = refresh, 1 = control). Read data appears on `bus_rdata` in the cycle after the request and holds until the next read.

Top module: `twostage_wdog`

## Requirements
- R1: After a synchronous reset, enable, both stage flags, both offset registers and both compare halves read as zero, and `irq_o` and `rst_req_o` are low.
- R2: In the control window, offset 0xFCC reads 0x0001043B. A read from the refresh window, or from any unmapped or misaligned (address bits [1:0] not zero) offset, returns zero.
- R3: The control/status register is at control offset 0x000: bit 0 is enable (written from bit 0 of the data), bit 1 is the first-stage flag and bit 2 is the second-stage flag. All other bits read as zero.
- R4: While enable (after the write) is 1, a write to refresh offset 0x000, or to control offsets 0x000, 0x008 or 0x00C, loads the compare value with the count sampled at that clock edge plus the 48-bit offset. The low and high halves of the compare value read at control offsets 0x010 and 0x014.
- R5: The offset is {bits [15:0] of control 0x00C, control 0x008}. Offset 0x00C reads back those 16 bits zero-extended. A write to 0x008 also sets the high offset bits to zero.
- R6: Any write to the refresh register, the control/status register or either offset register clears both stage flags, which drops `irq_o`.
- R7: When enabled and the count is greater than or equal to the compare value while the first-stage flag is clear, the first-stage flag sets, `irq_o` goes high, and the compare value is reloaded with that count plus the offset; all of this is visible after that clock edge.
- R8: When enabled and the count reaches the compare value while the first-stage flag is set, the second-stage flag sets and `rst_req_o` goes high. `rst_req_o` stays high until block reset, even after the flags are cleared.
- R9: While enable is 0, no expiry takes place and the flags and the interrupt stay clear.
- R10: Writes to control offsets 0x010 and 0x014 replace that half of the compare value, and the next expiry uses the written value.
- R11: Writes to unmapped or misaligned offsets change no register. A read of the refresh register changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system count |
| bus_valid | input | 1 | Bus access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | Window select: 0 = refresh, 1 = control |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | First-stage interrupt, level, follows the first-stage flag |
| rst_req_o | output | 1 | Second-stage reset request, sticky until reset |

## Verification
The assertions assume that `sys_count` increases by at most one per cycle from a small value, so it never wraps past the compare value, and that at most one bus access is made per cycle. The bench drives the count as a plain counter that increments every clock from zero and uses offsets of tens of cycles. Under these conditions each expiry time can be predicted exactly from the count sampled at the write edge. Every scenario starts from a block reset, so a sticky reset request from one scenario does not carry into the next.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 12;

  // control window layout
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFS_LO = 12'h008;
  localparam logic [ADDR_W-1:0] A_OFS_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;
  // refresh window layout
  localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;

  localparam logic [31:0] IDENT_VALUE = 32'h0001_043B;

  typedef struct packed {
    logic kick;
    logic ctrl;
    logic ofs_lo;
    logic ofs_hi;
    logic cmp_lo;
    logic cmp_hi;
    logic ident;
  } reg_sel_t;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
(
  input  logic              frame,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel = '0;
    if (addr[1:0] == 2'b00) begin
      if (!frame) begin
        sel.kick = (addr == A_KICK);
      end else begin
        unique case (addr)
          A_CTRL:   sel.ctrl   = 1'b1;
          A_OFS_LO: sel.ofs_lo = 1'b1;
          A_OFS_HI: sel.ofs_hi = 1'b1;
          A_CMP_LO: sel.cmp_lo = 1'b1;
          A_CMP_HI: sel.cmp_hi = 1'b1;
          A_IDENT:  sel.ident  = 1'b1;
          default:  sel        = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdt_reload_calc.sv
module wdt_reload_calc #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OFS_W = 48
) (
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] offset,
  output logic [CNT_W-1:0] deadline
);
  always_comb deadline = count + CNT_W'(offset);
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] deadline,
  output logic             hit
);
  always_comb hit = enable && (count >= deadline);
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned OFS_HI_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       sys_count,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int unsigned OFS_W = 32 + OFS_HI_W;

  reg_sel_t             sel;
  logic                 en_q, st1_q, st2_q, rreq_q;
  logic [31:0]          ofs_lo_q, ofs_lo_n;
  logic [OFS_HI_W-1:0]  ofs_hi_q, ofs_hi_n;
  logic [CNT_W-1:0]     cmp_q, reload_val, count_w;
  logic [63:0]          cmp_wide;
  logic [31:0]          rdata_q;
  logic                 wr, rd, kick, en_n, hit;

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign count_w  = CNT_W'(sys_count);
  assign cmp_wide = 64'(cmp_q);

  wdt_decode u_dec (.frame(bus_frame), .addr(bus_addr), .sel(sel));

  // next-state of the timing parameters as seen by a reload this cycle
  assign kick     = wr & (sel.kick | sel.ctrl | sel.ofs_lo | sel.ofs_hi);
  assign en_n     = (wr & sel.ctrl) ? bus_wdata[0] : en_q;
  assign ofs_lo_n = (wr & sel.ofs_lo) ? bus_wdata : ofs_lo_q;
  assign ofs_hi_n = (wr & sel.ofs_lo) ? '0 :
                    (wr & sel.ofs_hi) ? bus_wdata[OFS_HI_W-1:0] : ofs_hi_q;

  wdt_reload_calc #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_calc (
    .count(count_w), .offset({ofs_hi_n, ofs_lo_n}), .deadline(reload_val));

  wdt_expiry #(.CNT_W(CNT_W)) u_exp (
    .enable(en_q), .count(count_w), .deadline(cmp_q), .hit(hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      st1_q    <= 1'b0;
      st2_q    <= 1'b0;
      rreq_q   <= 1'b0;
      ofs_lo_q <= '0;
      ofs_hi_q <= '0;
      cmp_q    <= '0;
    end else if (wr) begin
      en_q     <= en_n;
      ofs_lo_q <= ofs_lo_n;
      ofs_hi_q <= ofs_hi_n;
      if (kick) begin
        st1_q <= 1'b0;
        st2_q <= 1'b0;
        if (en_n) cmp_q <= reload_val;
      end
      if (sel.cmp_lo) cmp_q <= CNT_W'({cmp_wide[63:32], bus_wdata});
      if (sel.cmp_hi) cmp_q <= CNT_W'({bus_wdata, cmp_wide[31:0]});
    end else if (hit) begin
      if (!st1_q) begin
        st1_q <= 1'b1;
        cmp_q <= reload_val;
      end else begin
        st2_q  <= 1'b1;
        rreq_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= '0;
      if (sel.ctrl)   rdata_q <= {29'd0, st2_q, st1_q, en_q};
      if (sel.ofs_lo) rdata_q <= ofs_lo_q;
      if (sel.ofs_hi) rdata_q <= 32'(ofs_hi_q);
      if (sel.cmp_lo) rdata_q <= cmp_wide[31:0];
      if (sel.cmp_hi) rdata_q <= cmp_wide[63:32];
      if (sel.ident)  rdata_q <= IDENT_VALUE;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = st1_q;
  assign rst_req_o = rreq_q;

  // R8
  rstreq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> rst_req_o);
  // R8
  stage2_after_stage1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st2_q) |-> $past(st1_q));
  // R9
  no_fire_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(en_q));
  // R6
  kick_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (!irq_o && !st2_q));
  // R11
  idle_keeps_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && !hit) |=> $stable(cmp_q));
endmodule

// File: tb/tb_twostage_wdog.sv
`timescale 1ns/1ps
module tb_twostage_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = 64'd0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) cnt <= cnt + 64'd1;

  twostage_wdog dut (
    .clk(clk), .rst(rst), .sys_count(cnt), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_frame(bus_frame), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic fr, input logic [11:0] a, input logic [31:0] d,
                    output logic [63:0] at);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_frame = fr; bus_addr = a; bus_wdata = d;
    at = cnt;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic fr, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_frame = fr; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int lim, output logic [63:0] seen);
    seen = '1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq_o) begin seen = cnt; break; end
    end
  endtask

  task automatic wait_rreq(input int lim, output logic [63:0] seen);
    seen = '1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rst_req_o) begin seen = cnt; break; end
    end
  endtask

  task automatic t_reset_and_ident();
    logic [31:0] d;
    do_reset();
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 rst_req", 64'(rst_req_o), 0);
    rd(1, 12'h000, d); chk("R1 ctrl", 64'(d), 0);
    rd(1, 12'h008, d); chk("R1 ofs_lo", 64'(d), 0);
    rd(1, 12'h00C, d); chk("R1 ofs_hi", 64'(d), 0);
    rd(1, 12'h010, d); chk("R1 cmp_lo", 64'(d), 0);
    rd(1, 12'h014, d); chk("R1 cmp_hi", 64'(d), 0);
    rd(1, 12'hFCC, d); chk("R2 ident", 64'(d), 64'h0001043B);
    rd(0, 12'h000, d); chk("R2 refresh read", 64'(d), 0);
    rd(1, 12'h018, d); chk("R2 unmapped read", 64'(d), 0);
    rd(1, 12'hFCD, d); chk("R2 misaligned read", 64'(d), 0);
  endtask

  task automatic t_offset_compose();
    logic [31:0] d; logic [63:0] at, exp;
    do_reset();
    wr(1, 12'h008, 32'h20, at);
    wr(1, 12'h00C, 32'h0001_0005, at);
    rd(1, 12'h00C, d); chk("R5 ofs_hi 16 bits", 64'(d), 64'h5);
    wr(1, 12'h000, 32'h1, at);
    exp = at + 64'h5_0000_0020;
    rd(1, 12'h010, d); chk("R4 cmp_lo", 64'(d), 64'(exp[31:0]));
    rd(1, 12'h014, d); chk("R4 cmp_hi", 64'(d), 64'(exp[63:32]));
    rd(1, 12'h000, d); chk("R3 ctrl enable", 64'(d), 64'h1);
    wr(1, 12'h008, 32'h40, at);
    rd(1, 12'h00C, d); chk("R5 ofs_lo zeroes hi", 64'(d), 0);
    rd(1, 12'h010, d); chk("R4 reload on ofs_lo", 64'(d), 64'(32'(at + 64'h40)));
    rd(1, 12'h014, d); chk("R4 reload hi", 64'(d), 64'(32'((at + 64'h40) >> 32)));
  endtask

  task automatic t_two_stage();
    logic [31:0] d; logic [63:0] at, seen, c1;
    do_reset();
    wr(1, 12'h008, 32'd30, at);
    wr(1, 12'h000, 32'h1, at);
    c1 = at + 30;
    wait_irq(200, seen);
    chk("R7 first expiry time", seen, c1 + 1);
    rd(1, 12'h010, d); chk("R7 reload cmp", 64'(d), 64'(32'(c1 + 30)));
    rd(0, 12'h000, d); chk("R2 refresh read zero", 64'(d), 0);
    rd(1, 12'h000, d); chk("R11 refresh read no effect / R3 flags", 64'(d), 64'h3);
    chk("R7 no reset req yet", 64'(rst_req_o), 0);
    wait_rreq(200, seen);
    chk("R8 second expiry time", seen, c1 + 31);
    rd(1, 12'h000, d); chk("R8 ctrl both flags", 64'(d), 64'h7);
    wr(0, 12'h000, 32'h0, at);
    rd(1, 12'h000, d); chk("R6 refresh clears flags", 64'(d), 64'h1);
    chk("R6 irq dropped", 64'(irq_o), 0);
    chk("R8 reset req sticky", 64'(rst_req_o), 1);
    rd(1, 12'h010, d); chk("R4 refresh reload", 64'(d), 64'(32'(at + 30)));
    do_reset();
    chk("R1 reset clears reset req", 64'(rst_req_o), 0);
  endtask

  task automatic t_ctrl_write_clears();
    logic [31:0] d; logic [63:0] at, seen;
    do_reset();
    wr(1, 12'h008, 32'd10, at);
    wr(1, 12'h000, 32'h1, at);
    wait_irq(100, seen);
    chk("R7 irq raised", 64'(irq_o), 1);
    wr(1, 12'h00C, 32'h0, at);
    rd(1, 12'h000, d); chk("R6 ofs_hi write clears", 64'(d), 64'h1);
    chk("R6 irq low", 64'(irq_o), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d; logic [63:0] at;
    do_reset();
    wr(1, 12'h008, 32'd10, at);
    wr(1, 12'h000, 32'h1, at);
    wr(1, 12'h000, 32'h0, at);
    repeat (40) @(negedge clk);
    chk("R9 no irq disabled", 64'(irq_o), 0);
    rd(1, 12'h000, d); chk("R9 ctrl clear", 64'(d), 0);
  endtask

  task automatic t_cmp_write();
    logic [31:0] d; logic [63:0] at, seen, tgt;
    do_reset();
    wr(1, 12'h008, 32'd1000, at);
    wr(1, 12'h000, 32'h1, at);
    tgt = cnt + 64'd20;
    wr(1, 12'h014, tgt[63:32], at);
    wr(1, 12'h010, tgt[31:0], at);
    rd(1, 12'h010, d); chk("R10 cmp_lo written", 64'(d), 64'(tgt[31:0]));
    rd(1, 12'h000, d); chk("R10 cmp write keeps enable", 64'(d), 64'h1);
    wait_irq(200, seen);
    chk("R10 expiry at written cmp", seen, tgt + 1);
  endtask

  task automatic t_unmapped_write();
    logic [31:0] d; logic [63:0] at;
    do_reset();
    wr(1, 12'h008, 32'h55, at);
    wr(1, 12'h004, 32'hFFFF_FFFF, at);
    wr(1, 12'h009, 32'hFFFF_FFFF, at);
    wr(0, 12'h008, 32'hFFFF_FFFF, at);
    rd(1, 12'h008, d); chk("R11 ofs_lo untouched", 64'(d), 64'h55);
    rd(1, 12'h000, d); chk("R11 ctrl untouched", 64'(d), 0);
    rd(1, 12'h010, d); chk("R11 cmp untouched", 64'(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_and_ident();
    t_offset_compose();
    t_two_stage();
    t_ctrl_write_clears();
    t_disabled();
    t_cmp_write();
    t_unmapped_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule